// File: doc/BRIEF.md
# Host Aperture Window Translator

This block sits behind a host-bus memory aperture and turns every host access into one of two things. It can be a request onto a 32-bit on-chip backplane through a programmable 4 KB sliding window. It can also be a request to a fixed local target: the configuration EEPROM, a shadow copy of that EEPROM, the bus-interface core, or the system-control core. Three aperture maps exist. All of them start with a sliding window at offset 0. They differ in aperture size and in what sits in the 4 KB slots above it. The map is chosen by a layout code that the block captures only while reset is asserted.

A separate register port writes and reads two independent window base registers. The block keeps one host transaction in flight at a time. It holds the request towards the chosen target until that target acknowledges, then gives the host a one-cycle ready with the returned data. An access beyond the active aperture issues no request. It completes with all-ones read data and a one-cycle error flag.

Top module: `bar_xlate`

## Requirements
- R1: Window base registers: `r_sel`=0 selects window 1 and `r_sel`=1 selects window 2. A write keeps bits [31:12] and forces bits [11:0] to zero. `r_rdata` shows the register picked by `r_sel`. Both registers reset to zero, and a write to one leaves the other unchanged.
- R2: In every layout, host offsets 0x0000–0x0FFF produce a backplane request at window-1 base plus the offset. The request carries the host's write flag and write data, and a read returns the backplane's read data.
- R3: Layout code 0 gives an 8 KB map. 0x1000–0x17FF is EEPROM space, with local address = offset − 0x1000. 0x1800–0x1BFF goes to the bus core (`loc_sel`=2) at 0x000–0x3FF. 0x1C00–0x1FFF goes to the bus core at 0xC00–0xFFF.
- R4: Layout code 1 gives a 16 KB map. Slot 0x1000 is EEPROM space, slot 0x2000 is the bus core (`loc_sel`=2) and slot 0x3000 is the system-control core (`loc_sel`=3). In each case the local address is the offset within the 4 KB slot.
- R5: Layout codes 2 and 3 give a 16 KB map. Slot 0x1000 is a second sliding window onto the backplane at window-2 base plus the slot offset. Slots 0x2000 and 0x3000 map as in R4. This map has no EEPROM space.
- R6: An EEPROM-space access uses `loc_sel`=0 (real EEPROM) when `cfg_eeprom_shadow` is 0 and `loc_sel`=1 (shadow in the bus core) when it is 1.
- R7: An access at or above the active aperture size (0x2000 for code 0, 0x4000 otherwise) raises neither `bp_req` nor `loc_req`. It completes with `h_rdata`=0xFFFFFFFF and `h_err` high only in the single `h_ready` cycle.
- R8: One transaction at a time. The target request rises on the edge after `h_valid` is seen while idle. It stays high with a stable address until sampled with its acknowledge. `h_ready` is high for exactly the one cycle after the acknowledge edge.
- R9: `cfg_layout` is captured only while `rst_n` is low. Changing it afterwards has no effect on the map.
- R10: `bp_req` and `loc_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_layout | input | 2 | Aperture map code, captured during reset |
| cfg_eeprom_shadow | input | 1 | Static select: 0 real EEPROM, 1 shadow copy |
| h_valid | input | 1 | Host access request, held until `h_ready` |
| h_write | input | 1 | Host access is a write |
| h_addr | input | 16 | Offset into the aperture |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | One-cycle completion of the host access |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_err | output | 1 | Out-of-aperture flag, valid with `h_ready` |
| r_wen | input | 1 | Window base register write strobe |
| r_sel | input | 1 | Window register select (0 window 1, 1 window 2) |
| r_wdata | input | 32 | Window base write data |
| r_rdata | output | 32 | Selected window base readback |
| bp_req | output | 1 | Backplane request, held until acknowledged |
| bp_write | output | 1 | Backplane request is a write |
| bp_addr | output | 32 | Translated backplane address |
| bp_wdata | output | 32 | Backplane write data |
| bp_ack | input | 1 | Backplane acknowledge |
| bp_rdata | input | 32 | Backplane read data, valid with `bp_ack` |
| loc_req | output | 1 | Local target request, held until acknowledged |
| loc_write | output | 1 | Local request is a write |
| loc_sel | output | 2 | Local target: 0 EEPROM, 1 shadow, 2 bus core, 3 system control |
| loc_addr | output | 12 | Target-relative local address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local target acknowledge |
| loc_rdata | input | 32 | Local read data, valid with `loc_ack` |

## Verification
The assertions watch on every cycle that the two target requests never overlap and that a request holds its address and direction until acknowledged. They also check that ready follows each acknowledge by one cycle and lasts one cycle, that an error completion carries all-ones data and no request, and that a register write shows up on readback. The address arithmetic of each layout, the EEPROM/shadow choice, the aperture limits and the reset-only capture of the layout code can only be shown by the bench's scenarios. The bench compares the captured requests against a reference map across all layout codes.

// File: rtl/bar_xlate_pkg.sv
// Package: shared types for the host aperture translator.
// Assumes layout codes 2 and 3 both select the dual-window map.
package bar_xlate_pkg;

    typedef enum logic [1:0] {
        MAP_SMALL = 2'd0,   // 8 KB: window + EEPROM + split bus core
        MAP_FIXED = 2'd1,   // 16 KB: window + EEPROM + bus core + sysctl
        MAP_DUAL  = 2'd2    // 16 KB: two windows + bus core + sysctl
    } map_e;

    typedef enum logic [1:0] {
        RT_WIN = 2'd0,
        RT_LOC = 2'd1,
        RT_ERR = 2'd2
    } route_e;

    localparam logic [1:0] LOC_EEPROM  = 2'd0;
    localparam logic [1:0] LOC_SHADOW  = 2'd1;
    localparam logic [1:0] LOC_BUSCORE = 2'd2;
    localparam logic [1:0] LOC_SYSCTL  = 2'd3;

    // Turn a raw layout code into a map kind.
    function automatic map_e map_of(input logic [1:0] code);
        case (code)
            2'd0:    return MAP_SMALL;
            2'd1:    return MAP_FIXED;
            default: return MAP_DUAL;
        endcase
    endfunction

endpackage

// File: rtl/bar_win_regs.sv
// Module: bar_win_regs
// Holds NWIN independent window base registers, each aligned to a
// 2**SLOT_BITS byte slot. Low bits are dropped on write and read as zero.
// Assumes a single write strobe with a select, and combinational readback.
module bar_win_regs #(
    parameter int BP_AW     = 32,
    parameter int SLOT_BITS = 12,
    parameter int NWIN      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NWIN)-1:0] sel,
    input  logic [BP_AW-1:0]        wr_data,
    output logic [BP_AW-1:0]        rd_data,
    output logic [BP_AW-1:0]        base [NWIN]
);
    localparam logic [BP_AW-1:0] ALIGN_MASK = ~((BP_AW)'((1 << SLOT_BITS) - 1));

    logic [BP_AW-1:0] base_q [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        // Load one aligned base when its select matches.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[w] <= '0;
            end else if (wr_en && (sel == ($clog2(NWIN))'(w))) begin
                base_q[w] <= wr_data & ALIGN_MASK;
            end
        end
        assign base[w] = base_q[w];
    end

    // Return the selected base.
    assign rd_data = base_q[sel];

endmodule

// File: rtl/bar_decode.sv
// Module: bar_decode
// Pure combinational map from an aperture offset to a target. The offset
// is split into a 4 KB slot index and a slot-relative part. Slot 0 is
// always window 1. The upper slots depend on the map kind. Assumes the
// window bases are slot aligned, so the add never carries into them.
module bar_decode
    import bar_xlate_pkg::*;
#(
    parameter int HOST_AW   = 16,
    parameter int BP_AW     = 32,
    parameter int SLOT_BITS = 12
) (
    input  map_e                 map,
    input  logic                 shadow,
    input  logic [HOST_AW-1:0]   offset,
    input  logic [BP_AW-1:0]     base1,
    input  logic [BP_AW-1:0]     base2,
    output route_e               route,
    output logic [BP_AW-1:0]     bp_addr,
    output logic [1:0]           loc_sel,
    output logic [SLOT_BITS-1:0] loc_addr
);
    localparam int IDX_W = HOST_AW - SLOT_BITS;

    logic [IDX_W-1:0]     slot;
    logic [SLOT_BITS-1:0] rel;
    logic [BP_AW-1:0]     rel_wide;
    logic [1:0]           eep_sel;

    assign slot     = offset[HOST_AW-1:SLOT_BITS];
    assign rel      = offset[SLOT_BITS-1:0];
    assign rel_wide = {{(BP_AW-SLOT_BITS){1'b0}}, rel};
    assign eep_sel  = shadow ? LOC_SHADOW : LOC_EEPROM;

    // Choose the target and its address for the current offset.
    always_comb begin
        route    = RT_ERR;
        bp_addr  = '0;
        loc_sel  = LOC_EEPROM;
        loc_addr = '0;
        if (slot == IDX_W'(0)) begin
            route   = RT_WIN;
            bp_addr = base1 + rel_wide;
        end else if (map == MAP_SMALL) begin
            if (slot == IDX_W'(1)) begin
                route = RT_LOC;
                if (!rel[SLOT_BITS-1]) begin
                    // lower half of the slot: EEPROM space
                    loc_sel  = eep_sel;
                    loc_addr = {1'b0, rel[SLOT_BITS-2:0]};
                end else begin
                    // upper quarters: bus core low block or agent block
                    loc_sel  = LOC_BUSCORE;
                    loc_addr = {rel[SLOT_BITS-2], rel[SLOT_BITS-2],
                                rel[SLOT_BITS-3:0]};
                end
            end
        end else begin
            if (slot == IDX_W'(1)) begin
                if (map == MAP_DUAL) begin
                    route   = RT_WIN;
                    bp_addr = base2 + rel_wide;
                end else begin
                    route    = RT_LOC;
                    loc_sel  = eep_sel;
                    loc_addr = rel;
                end
            end else if (slot == IDX_W'(2)) begin
                route    = RT_LOC;
                loc_sel  = LOC_BUSCORE;
                loc_addr = rel;
            end else if (slot == IDX_W'(3)) begin
                route    = RT_LOC;
                loc_sel  = LOC_SYSCTL;
                loc_addr = rel;
            end
        end
    end

endmodule

// File: rtl/bar_host_fsm.sv
// Module: bar_host_fsm
// Sequences one host access at a time. When idle it accepts the
// request, registers the decoded target request and holds it until
// acknowledged. It then gives one ready cycle with the captured data.
// Out-of-aperture accesses skip the target and complete with all-ones
// data and an error flag. Assumes the host holds its request stable
// until ready.
module bar_host_fsm
    import bar_xlate_pkg::*;
#(
    parameter int DW        = 32,
    parameter int BP_AW     = 32,
    parameter int SLOT_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_valid,
    input  logic                 h_write,
    input  logic [DW-1:0]        h_wdata,
    output logic                 h_ready,
    output logic [DW-1:0]        h_rdata,
    output logic                 h_err,
    input  route_e               route,
    input  logic [BP_AW-1:0]     dec_bp_addr,
    input  logic [1:0]           dec_loc_sel,
    input  logic [SLOT_BITS-1:0] dec_loc_addr,
    output logic                 bp_req,
    output logic                 bp_write,
    output logic [BP_AW-1:0]     bp_addr,
    output logic [DW-1:0]        bp_wdata,
    input  logic                 bp_ack,
    input  logic [DW-1:0]        bp_rdata,
    output logic                 loc_req,
    output logic                 loc_write,
    output logic [1:0]           loc_sel,
    output logic [SLOT_BITS-1:0] loc_addr,
    output logic [DW-1:0]        loc_wdata,
    input  logic                 loc_ack,
    input  logic [DW-1:0]        loc_rdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;

    state_e state_q;

    // Advance the access sequence and hold the registered target request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            h_rdata   <= '0;
            h_err     <= 1'b0;
            bp_req    <= 1'b0;
            bp_write  <= 1'b0;
            bp_addr   <= '0;
            bp_wdata  <= '0;
            loc_req   <= 1'b0;
            loc_write <= 1'b0;
            loc_sel   <= LOC_EEPROM;
            loc_addr  <= '0;
            loc_wdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (h_valid) begin
                        case (route)
                            RT_WIN: begin
                                bp_req   <= 1'b1;
                                bp_write <= h_write;
                                bp_addr  <= dec_bp_addr;
                                bp_wdata <= h_wdata;
                                state_q  <= ST_WAIT;
                            end
                            RT_LOC: begin
                                loc_req   <= 1'b1;
                                loc_write <= h_write;
                                loc_sel   <= dec_loc_sel;
                                loc_addr  <= dec_loc_addr;
                                loc_wdata <= h_wdata;
                                state_q   <= ST_WAIT;
                            end
                            default: begin
                                h_rdata <= '1;
                                h_err   <= 1'b1;
                                state_q <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (bp_req && bp_ack) begin
                        bp_req  <= 1'b0;
                        h_rdata <= bp_rdata;
                        state_q <= ST_DONE;
                    end else if (loc_req && loc_ack) begin
                        loc_req <= 1'b0;
                        h_rdata <= loc_rdata;
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    h_err   <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Ready is the single completion cycle.
    assign h_ready = (state_q == ST_DONE);

endmodule

// File: rtl/bar_xlate.sv
// Module: bar_xlate (top)
// Host aperture translator. It captures the layout code during reset,
// holds the two window bases, decodes each host offset and sequences the
// access to the backplane or to a local target. Assumes the EEPROM
// shadow select changes only while no access is in flight.
module bar_xlate
    import bar_xlate_pkg::*;
#(
    parameter int HOST_AW   = 16,
    parameter int BP_AW     = 32,
    parameter int DW        = 32,
    parameter int SLOT_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_layout,
    input  logic                 cfg_eeprom_shadow,
    input  logic                 h_valid,
    input  logic                 h_write,
    input  logic [HOST_AW-1:0]   h_addr,
    input  logic [DW-1:0]        h_wdata,
    output logic                 h_ready,
    output logic [DW-1:0]        h_rdata,
    output logic                 h_err,
    input  logic                 r_wen,
    input  logic                 r_sel,
    input  logic [BP_AW-1:0]     r_wdata,
    output logic [BP_AW-1:0]     r_rdata,
    output logic                 bp_req,
    output logic                 bp_write,
    output logic [BP_AW-1:0]     bp_addr,
    output logic [DW-1:0]        bp_wdata,
    input  logic                 bp_ack,
    input  logic [DW-1:0]        bp_rdata,
    output logic                 loc_req,
    output logic                 loc_write,
    output logic [1:0]           loc_sel,
    output logic [SLOT_BITS-1:0] loc_addr,
    output logic [DW-1:0]        loc_wdata,
    input  logic                 loc_ack,
    input  logic [DW-1:0]        loc_rdata
);
    localparam int NWIN = 2;

    logic [1:0]           layout_q;
    logic [BP_AW-1:0]     win_base [NWIN];
    route_e               dec_route;
    logic [BP_AW-1:0]     dec_bp_addr;
    logic [1:0]           dec_loc_sel;
    logic [SLOT_BITS-1:0] dec_loc_addr;

    // Capture the layout code only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q <= cfg_layout;
        end
    end

    bar_win_regs #(
        .BP_AW    (BP_AW),
        .SLOT_BITS(SLOT_BITS),
        .NWIN     (NWIN)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (r_wen),
        .sel    (r_sel),
        .wr_data(r_wdata),
        .rd_data(r_rdata),
        .base   (win_base)
    );

    bar_decode #(
        .HOST_AW  (HOST_AW),
        .BP_AW    (BP_AW),
        .SLOT_BITS(SLOT_BITS)
    ) u_dec (
        .map     (map_of(layout_q)),
        .shadow  (cfg_eeprom_shadow),
        .offset  (h_addr),
        .base1   (win_base[0]),
        .base2   (win_base[1]),
        .route   (dec_route),
        .bp_addr (dec_bp_addr),
        .loc_sel (dec_loc_sel),
        .loc_addr(dec_loc_addr)
    );

    bar_host_fsm #(
        .DW       (DW),
        .BP_AW    (BP_AW),
        .SLOT_BITS(SLOT_BITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_valid     (h_valid),
        .h_write     (h_write),
        .h_wdata     (h_wdata),
        .h_ready     (h_ready),
        .h_rdata     (h_rdata),
        .h_err       (h_err),
        .route       (dec_route),
        .dec_bp_addr (dec_bp_addr),
        .dec_loc_sel (dec_loc_sel),
        .dec_loc_addr(dec_loc_addr),
        .bp_req      (bp_req),
        .bp_write    (bp_write),
        .bp_addr     (bp_addr),
        .bp_wdata    (bp_wdata),
        .bp_ack      (bp_ack),
        .bp_rdata    (bp_rdata),
        .loc_req     (loc_req),
        .loc_write   (loc_write),
        .loc_sel     (loc_sel),
        .loc_addr    (loc_addr),
        .loc_wdata   (loc_wdata),
        .loc_ack     (loc_ack),
        .loc_rdata   (loc_rdata)
    );

endmodule

// File: rtl/bar_xlate_chk.sv
// Module: bar_xlate_chk
// Port-level protocol checker for bar_xlate, attached with bind.
// Assumes synchronous active-low reset.
module bar_xlate_chk #(
    parameter int DW        = 32,
    parameter int BP_AW     = 32,
    parameter int SLOT_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 h_ready,
    input logic                 h_err,
    input logic [DW-1:0]        h_rdata,
    input logic                 r_wen,
    input logic                 r_sel,
    input logic [BP_AW-1:0]     r_wdata,
    input logic [BP_AW-1:0]     r_rdata,
    input logic                 bp_req,
    input logic                 bp_ack,
    input logic                 bp_write,
    input logic [BP_AW-1:0]     bp_addr,
    input logic                 loc_req,
    input logic                 loc_ack,
    input logic                 loc_write,
    input logic [1:0]           loc_sel,
    input logic [SLOT_BITS-1:0] loc_addr
);
    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_req && loc_req));

    assert_bp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && !bp_ack) |=> (bp_req && $stable(bp_addr) && $stable(bp_write)));

    assert_loc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_sel)
                                   && $stable(loc_write)));

    assert_ack_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bp_req && bp_ack) || (loc_req && loc_ack)) |=> h_ready);

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);

    assert_err_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> (h_ready && (h_rdata == '1) && !bp_req && !loc_req));

    assert_reg_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_wen |=> ((r_sel != $past(r_sel)) ||
                   (r_rdata == {$past(r_wdata[BP_AW-1:SLOT_BITS]), {SLOT_BITS{1'b0}}})));

endmodule

bind bar_xlate bar_xlate_chk #(
    .DW       (DW),
    .BP_AW    (BP_AW),
    .SLOT_BITS(SLOT_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_ready  (h_ready),
    .h_err    (h_err),
    .h_rdata  (h_rdata),
    .r_wen    (r_wen),
    .r_sel    (r_sel),
    .r_wdata  (r_wdata),
    .r_rdata  (r_rdata),
    .bp_req   (bp_req),
    .bp_ack   (bp_ack),
    .bp_write (bp_write),
    .bp_addr  (bp_addr),
    .loc_req  (loc_req),
    .loc_ack  (loc_ack),
    .loc_write(loc_write),
    .loc_sel  (loc_sel),
    .loc_addr (loc_addr)
);

// File: tb/bar_xlate_tb.sv
// Bench for bar_xlate: directed corner cases plus seeded random traffic,
// compared against a reference map written from the requirements.
module bar_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_layout = 2'd0;
    logic        cfg_eeprom_shadow = 1'b0;
    logic        h_valid = 1'b0;
    logic        h_write = 1'b0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready;
    logic [31:0] h_rdata;
    logic        h_err;
    logic        r_wen = 1'b0;
    logic        r_sel = 1'b0;
    logic [31:0] r_wdata = '0;
    logic [31:0] r_rdata;
    logic        bp_req, bp_write;
    logic [31:0] bp_addr, bp_wdata;
    logic        bp_ack = 1'b0;
    logic [31:0] bp_rdata = '0;
    logic        loc_req, loc_write;
    logic [1:0]  loc_sel;
    logic [11:0] loc_addr;
    logic [31:0] loc_wdata;
    logic        loc_ack = 1'b0;
    logic [31:0] loc_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    bar_xlate u_dut (.*);

    // ---------------- target responders ----------------
    int          bp_cnt = 0, loc_cnt = 0;
    int          bp_wait = 0, loc_wait = 0;
    logic [31:0] rec_addr = '0, rec_wdata = '0;
    logic        rec_write = 1'b0;
    logic [1:0]  rec_sel = '0;

    function automatic logic [31:0] bp_data(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [31:0] loc_data(input logic [1:0] s, input logic [11:0] a);
        return {14'h2A5, s, 4'h0, a};
    endfunction

    always @(posedge clk) begin
        if (bp_req && !bp_ack) begin
            if (bp_wait == 0) begin
                bp_ack    <= 1'b1;
                bp_rdata  <= bp_data(bp_addr);
                rec_addr  <= bp_addr;
                rec_write <= bp_write;
                rec_wdata <= bp_wdata;
                bp_cnt    <= bp_cnt + 1;
            end else begin
                bp_wait <= bp_wait - 1;
            end
        end else begin
            bp_ack  <= 1'b0;
            bp_wait <= int'($urandom % 4);
        end
    end

    always @(posedge clk) begin
        if (loc_req && !loc_ack) begin
            if (loc_wait == 0) begin
                loc_ack   <= 1'b1;
                loc_rdata <= loc_data(loc_sel, loc_addr);
                rec_addr  <= {20'h0, loc_addr};
                rec_sel   <= loc_sel;
                rec_write <= loc_write;
                rec_wdata <= loc_wdata;
                loc_cnt   <= loc_cnt + 1;
            end else begin
                loc_wait <= loc_wait - 1;
            end
        end else begin
            loc_ack  <= 1'b0;
            loc_wait <= int'($urandom % 4);
        end
    end

    // ---------------- reference model ----------------
    logic [1:0]  m_layout = 2'd0;
    logic [31:0] m_b1 = '0, m_b2 = '0;

    // kind: 0 backplane, 1 local, 2 error
    function automatic void ref_map(input logic [1:0] lay, input logic shd,
                                    input logic [15:0] off, input logic [31:0] b1,
                                    input logic [31:0] b2, output int kind,
                                    output logic [31:0] addr, output logic [1:0] sel);
        int slot = int'(off >> 12);
        logic [31:0] rel = {20'h0, off[11:0]};
        kind = 2; addr = '0; sel = 2'd0;
        if (slot == 0) begin
            kind = 0; addr = b1 + rel;
        end else if (lay == 2'd0) begin
            if (slot == 1) begin
                kind = 1;
                if (rel < 32'h800)      begin sel = shd ? 2'd1 : 2'd0; addr = rel; end
                else if (rel < 32'hC00) begin sel = 2'd2; addr = rel - 32'h800; end
                else                    begin sel = 2'd2; addr = rel; end
            end
        end else if (slot == 1) begin
            if (lay == 2'd1) begin kind = 1; sel = shd ? 2'd1 : 2'd0; addr = rel; end
            else             begin kind = 0; addr = b2 + rel; end
        end else if (slot == 2) begin
            kind = 1; sel = 2'd2; addr = rel;
        end else if (slot == 3) begin
            kind = 1; sel = 2'd3; addr = rel;
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] lay, input logic shd);
        @(negedge clk);
        cfg_layout = lay; cfg_eeprom_shadow = shd; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_layout = lay; m_b1 = '0; m_b2 = '0;
    endtask

    task automatic write_reg(input logic s, input logic [31:0] d);
        @(negedge clk);
        r_wen = 1'b1; r_sel = s; r_wdata = d;
        @(negedge clk);
        r_wen = 1'b0;
        if (s) m_b2 = d & 32'hFFFF_F000; else m_b1 = d & 32'hFFFF_F000;
    endtask

    task automatic check_reg(input logic s, input string req);
        r_sel = s;
        #1;
        check(r_rdata == (s ? m_b2 : m_b1), req, "window base readback", r_rdata,
              s ? m_b2 : m_b1);
    endtask

    // One host access, compared with the reference map.
    task automatic host_access(input logic w, input logic [15:0] a,
                               input logic [31:0] d, input string req);
        int kind; logic [31:0] ea; logic [1:0] es;
        int bp0 = bp_cnt, loc0 = loc_cnt, cyc = 0;
        ref_map(m_layout, cfg_eeprom_shadow, a, m_b1, m_b2, kind, ea, es);
        @(negedge clk);
        h_valid = 1'b1; h_write = w; h_addr = a; h_wdata = d;
        do begin
            @(negedge clk);
            cyc++;
        end while (!h_ready && cyc < 64);
        check(h_ready == 1'b1, req, "ready within 64 cycles", 32'(cyc), 32'd64);
        if (kind == 2) begin
            check(h_err == 1'b1, req, "error flag", 32'(h_err), 32'd1);
            check(h_rdata == 32'hFFFF_FFFF, req, "error read data", h_rdata, 32'hFFFF_FFFF);
            check(bp_cnt == bp0 && loc_cnt == loc0, req, "no request on error",
                  32'(bp_cnt + loc_cnt - bp0 - loc0), 32'd0);
        end else begin
            check(h_err == 1'b0, req, "no error flag", 32'(h_err), 32'd0);
            if (kind == 0)
                check(bp_cnt == bp0 + 1 && loc_cnt == loc0, req, "backplane target taken",
                      32'(bp_cnt - bp0), 32'd1);
            else begin
                check(loc_cnt == loc0 + 1 && bp_cnt == bp0, req, "local target taken",
                      32'(loc_cnt - loc0), 32'd1);
                check(rec_sel == es, req, "local select", 32'(rec_sel), 32'(es));
            end
            check(rec_addr == ea, req, "target address", rec_addr, ea);
            check(rec_write == w, req, "write flag", 32'(rec_write), 32'(w));
            if (w)
                check(rec_wdata == d, req, "write data", rec_wdata, d);
            else begin
                logic [31:0] er;
                er = (kind == 0) ? bp_data(ea) : loc_data(es, ea[11:0]);
                check(h_rdata == er, req, "read data", h_rdata, er);
            end
        end
        h_valid = 1'b0;
        @(negedge clk);
        check(h_ready == 1'b0 && h_err == 1'b0, "R8", "ready/err one cycle",
              {30'h0, h_ready, h_err}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2718));

        // reset state (R1, R8)
        do_reset(2'd0, 1'b0);
        #1;
        check(!h_ready && !bp_req && !loc_req, "R8", "idle after reset",
              {29'h0, h_ready, bp_req, loc_req}, 32'd0);
        check_reg(1'b0, "R1");
        check_reg(1'b1, "R1");

        // R1: alignment and independence
        write_reg(1'b0, 32'hFFFF_FFFF);
        check_reg(1'b0, "R1");
        check_reg(1'b1, "R1");
        write_reg(1'b1, 32'h1234_5678);
        check_reg(1'b1, "R1");
        check_reg(1'b0, "R1");

        // layout code 0 (R2, R3, R6, R7)
        write_reg(1'b0, 32'h8000_3000);
        host_access(1'b0, 16'h0000, 32'h0, "R2");
        host_access(1'b1, 16'h0FFF, 32'hDEAD_BEEF, "R2");
        host_access(1'b0, 16'h1000, 32'h0, "R3");
        host_access(1'b0, 16'h17FF, 32'h0, "R3");
        host_access(1'b0, 16'h1800, 32'h0, "R3");
        host_access(1'b1, 16'h1BFF, 32'h0BAD_F00D, "R3");
        host_access(1'b0, 16'h1C00, 32'h0, "R3");
        host_access(1'b0, 16'h1FFF, 32'h0, "R3");
        host_access(1'b0, 16'h2000, 32'h0, "R7");
        host_access(1'b1, 16'hFFFF, 32'h1111_2222, "R7");
        cfg_eeprom_shadow = 1'b1;
        host_access(1'b0, 16'h1004, 32'h0, "R6");
        cfg_eeprom_shadow = 1'b0;
        host_access(1'b0, 16'h1004, 32'h0, "R6");

        // layout code 1 (R4, R6, R7)
        do_reset(2'd1, 1'b1);
        host_access(1'b0, 16'h1000, 32'h0, "R6");
        host_access(1'b0, 16'h1FFF, 32'h0, "R4");
        host_access(1'b1, 16'h2000, 32'h5555_AAAA, "R4");
        host_access(1'b0, 16'h3FFF, 32'h0, "R4");
        host_access(1'b0, 16'h4000, 32'h0, "R7");

        // layout code 2 and 3 (R5)
        do_reset(2'd2, 1'b0);
        write_reg(1'b0, 32'h1000_0000);
        write_reg(1'b1, 32'h2345_6000);
        host_access(1'b0, 16'h0010, 32'h0, "R5");
        host_access(1'b0, 16'h1ABC, 32'h0, "R5");
        host_access(1'b1, 16'h1FFF, 32'hCAFE_0001, "R5");
        host_access(1'b0, 16'h2004, 32'h0, "R5");
        host_access(1'b0, 16'h3008, 32'h0, "R5");
        host_access(1'b0, 16'h4000, 32'h0, "R7");
        do_reset(2'd3, 1'b1);
        write_reg(1'b1, 32'h7700_0000);
        host_access(1'b0, 16'h1000, 32'h0, "R5");

        // R9: layout input changes after reset are ignored
        do_reset(2'd1, 1'b0);
        @(negedge clk);
        cfg_layout = 2'd0;
        host_access(1'b0, 16'h3000, 32'h0, "R9");
        cfg_layout = 2'd2;
        host_access(1'b0, 16'h1000, 32'h0, "R9");

        // seeded random traffic over all map kinds (R2..R8)
        for (int lay = 0; lay < 3; lay++) begin
            do_reset(2'(lay), 1'($urandom % 2));
            write_reg(1'b0, $urandom);
            write_reg(1'b1, $urandom);
            check_reg(1'b0, "R1");
            check_reg(1'b1, "R1");
            for (int i = 0; i < 40; i++) begin
                logic [15:0] off;
                off = 16'($urandom % 32'h5000);
                if ((i % 8) == 7) cfg_eeprom_shadow = ~cfg_eeprom_shadow;
                host_access(1'($urandom % 2), off, $urandom, "R8");
            end
        end

        finish_up();
    end

endmodule